// File: doc/BRIEF.md
# Two-Level SMI Status Aggregator

This block gathers system-management interrupt events from six hardware sources and keeps them in a sticky second-level status register, one bit per source. A single summary bit sits above that register. The block drives an SMI request line while any status is pending. Each source has its own enable. The configuration-trap source is enabled per trapped register space and sets one shared status bit.

Software sees the block through a simple combinational read port with three views of the same state. The top-level status word shows the summary bit. A read-only mirror shows the second-level bits and has no side effects. The primary status address shows the same bits and clears both levels, which drops the SMI line. A fourth address raises an SMI request when it is read, but only if its enable input is set; the data it returns carries no meaning.

Read addresses are byte offsets: top word 00h, mirror 04h, primary 06h, speedup 08h. Read data is valid in the same cycle as `rd_en`. A clearing read takes effect at the clock edge that ends that cycle.

Top module: `smi_status_agg`

## Requirements
- R1: After reset, the primary and mirror status read 0000h, the top word reads 0000h and `smi_o` is 0.
- R2: The second-level status bits are assigned as follows: bit 0 is timer 1 expiry, bit 1 is timer 2 expiry, bits 2, 3 and 4 are trapped accesses to user devices 1, 2 and 3, and bit 5 is a configuration-cycle trap. Bits 15:6 read 0. A pending bit makes `smi_o` 1 in the cycle after its event.
- R3: A source event sets its bit only when its enable is 1. Timer 1 and timer 2 use `tmr_ctl` bits 0 and 1. User devices 1, 2 and 3 use `udev_ctl` bits 4, 5 and 6. A disabled event leaves the status and `smi_o` unchanged.
- R4: A configuration trap on space k (`cfg_trap[k]`) sets bit 5 only when `cfg_trap_en[k]` is 1. A trap on any enabled space sets the bit.
- R5: Status bits are sticky. They stay set through idle cycles and through other events until a primary read clears them.
- R6: A read of the top word (00h) returns the summary in bit 9 and 0 in every other bit. The summary is 1 whenever any second-level bit is 1.
- R7: A read of the primary address (06h) returns the status. In the next cycle the status, the summary and `smi_o` are all 0, provided no new event arrives.
- R8: A read of the mirror address (04h) returns the same bits as the primary address. It clears nothing and leaves `smi_o` unchanged.
- R9: A read of the speedup address (08h) with `spd_en`=1 makes `smi_o` 1 in the next cycle, and the request stays pending until a primary read. With `spd_en`=0 the read has no effect.
- R10: An enabled event in the same cycle as a primary read is kept. Its bit is set in the cycle after the clear.
- R11: `smi_o` is the OR of the summary and any pending speedup request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_tmr | input | 2 | Timer expiry pulses (bit 0 timer 1, bit 1 timer 2) |
| evt_udev | input | 3 | User-device trap pulses (devices 1 to 3) |
| cfg_trap | input | 6 | Configuration-trap pulses, one per register space |
| tmr_ctl | input | 8 | Timer enable byte (bits 0, 1) |
| udev_ctl | input | 8 | User-device enable byte (bits 4, 5, 6) |
| cfg_trap_en | input | 6 | Per-space configuration-trap enables |
| spd_en | input | 1 | Enables SMI on a speedup-address read |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Read data for the addressed view |
| smi_o | output | 1 | SMI request |

## Verification
A wrong status bit or a lost event shows up in the next mirror read, one cycle after the event. A clear that fails to happen leaves `smi_o` high in the cycle after a primary read. A clear that happens when it should not is exposed by a second mirror read, which disagrees with the first one. A summary register that drifts from the second-level bits shows up as a wrong bit 9 in the top word, or as an `smi_o` value that the status alone does not explain, one cycle after the disturbing access.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int STAT_W   = 16;
  localparam int NSRC     = 6;
  localparam int SUM_BIT  = 9;
  localparam int ADDR_W   = 8;
  localparam int B_TMR1   = 0;
  localparam int B_UDEV1  = 2;
  localparam int B_CFG    = 5;
  localparam int UDEV_EN0 = 4;
  localparam logic [ADDR_W-1:0] A_TOP = 8'h00;
  localparam logic [ADDR_W-1:0] A_MIR = 8'h04;
  localparam logic [ADDR_W-1:0] A_PRI = 8'h06;
  localparam logic [ADDR_W-1:0] A_SPD = 8'h08;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/smi_src_gate.sv
module smi_src_gate
  import smi_agg_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int N_UDEV = 3,
  parameter int N_CFG = 6
) (
  input  logic [N_TMR-1:0]  evt_tmr,
  input  logic [N_UDEV-1:0] evt_udev,
  input  logic [N_CFG-1:0]  cfg_trap,
  input  logic [7:0]        tmr_ctl,
  input  logic [7:0]        udev_ctl,
  input  logic [N_CFG-1:0]  cfg_trap_en,
  output src_vec_t          set_vec
);
  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N_TMR; i++) begin
      set_vec[B_TMR1+i] = evt_tmr[i] & tmr_ctl[i];
    end
    for (int j = 0; j < N_UDEV; j++) begin
      set_vec[B_UDEV1+j] = evt_udev[j] & udev_ctl[UDEV_EN0+j];
    end
    set_vec[B_CFG] = |(cfg_trap & cfg_trap_en);
  end
endmodule

// File: rtl/smi_stat_reg.sv
module smi_stat_reg
  import smi_agg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  logic     clr,
  input  logic     spd_set,
  output src_vec_t stat_q,
  output logic     sum_q,
  output logic     spd_q
);
  src_vec_t stat_d;
  logic     sum_d;
  logic     spd_d;
  logic     upd;

  always_comb begin
    stat_d = (clr ? '0 : stat_q) | set_vec;
    sum_d  = (clr ? 1'b0 : sum_q) | (|set_vec);
    spd_d  = (clr ? 1'b0 : spd_q) | spd_set;
    upd    = clr | spd_set | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      sum_q  <= 1'b0;
      spd_q  <= 1'b0;
    end else if (upd) begin
      stat_q <= stat_d;
      sum_q  <= sum_d;
      spd_q  <= spd_d;
    end
  end
endmodule

// File: rtl/smi_rd_port.sv
module smi_rd_port
  import smi_agg_pkg::*;
(
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  src_vec_t          stat_q,
  input  logic              sum_q,
  input  logic              spd_en,
  output logic [STAT_W-1:0] rd_data,
  output logic              clr,
  output logic              spd_set
);
  always_comb begin
    rd_data = '0;
    clr     = 1'b0;
    spd_set = 1'b0;
    if (rd_en) begin
      unique case (rd_addr)
        A_TOP: rd_data[SUM_BIT] = sum_q;
        A_MIR: rd_data[NSRC-1:0] = stat_q;
        A_PRI: begin
          rd_data[NSRC-1:0] = stat_q;
          clr = 1'b1;
        end
        A_SPD: spd_set = spd_en;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_agg_pkg::*;
#(
  parameter int N_CFG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        evt_tmr,
  input  logic [2:0]        evt_udev,
  input  logic [N_CFG-1:0]  cfg_trap,
  input  logic [7:0]        tmr_ctl,
  input  logic [7:0]        udev_ctl,
  input  logic [N_CFG-1:0]  cfg_trap_en,
  input  logic              spd_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_data,
  output logic              smi_o
);
  logic     rst_meta;
  logic     rst_sync_n;
  src_vec_t set_vec;
  src_vec_t stat_q;
  logic     sum_q;
  logic     spd_q;
  logic     clr;
  logic     spd_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  smi_src_gate #(.N_TMR(2), .N_UDEV(3), .N_CFG(N_CFG)) u_gate (
    .evt_tmr(evt_tmr), .evt_udev(evt_udev), .cfg_trap(cfg_trap),
    .tmr_ctl(tmr_ctl), .udev_ctl(udev_ctl), .cfg_trap_en(cfg_trap_en),
    .set_vec(set_vec)
  );

  smi_rd_port u_rd (
    .rd_en(rd_en), .rd_addr(rd_addr), .stat_q(stat_q), .sum_q(sum_q),
    .spd_en(spd_en), .rd_data(rd_data), .clr(clr), .spd_set(spd_set)
  );

  smi_stat_reg u_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec), .clr(clr),
    .spd_set(spd_set), .stat_q(stat_q), .sum_q(sum_q), .spd_q(spd_q)
  );

  assign smi_o = sum_q | spd_q;
endmodule

// File: rtl/smi_status_agg_chk.sv
module smi_status_agg_chk
  import smi_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [STAT_W-1:0] rd_data,
  input src_vec_t          set_vec,
  input src_vec_t          stat_q,
  input logic              sum_q,
  input logic              spd_q,
  input logic              spd_en,
  input logic              smi_o
);
  logic pri_rd;
  assign pri_rd = rd_en && (rd_addr == A_PRI);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == A_PRI || rd_addr == A_MIR)) |-> (rd_data[STAT_W-1:NSRC] == '0)); // R2
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5
  AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q == (|stat_q)); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_rd && set_vec == '0) |=> (stat_q == '0 && !smi_o)); // R7
  AST_MIRROR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_MIR) |=> (stat_q == ($past(stat_q) | $past(set_vec)))); // R8
  AST_SPD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_SPD && !spd_en && !spd_q) |=> !spd_q); // R9
  AST_COINCIDENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_rd && set_vec != '0) |=> (stat_q == $past(set_vec))); // R10
endmodule

bind smi_status_agg smi_status_agg_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .set_vec(set_vec), .stat_q(stat_q), .sum_q(sum_q),
  .spd_q(spd_q), .spd_en(spd_en), .smi_o(smi_o)
);

// File: tb/smi_status_agg_tb.sv
module smi_status_agg_tb;
  localparam int PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  evt_tmr;
  logic [2:0]  evt_udev;
  logic [5:0]  cfg_trap;
  logic [7:0]  tmr_ctl;
  logic [7:0]  udev_ctl;
  logic [5:0]  cfg_trap_en;
  logic        spd_en;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic        smi_o;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } item_t;
  item_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;
  logic [5:0] m_stat;
  logic       m_spd;

  smi_status_agg u_dut (
    .clk(clk), .rst_n(rst_n), .evt_tmr(evt_tmr), .evt_udev(evt_udev),
    .cfg_trap(cfg_trap), .tmr_ctl(tmr_ctl), .udev_ctl(udev_ctl),
    .cfg_trap_en(cfg_trap_en), .spd_en(spd_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .smi_o(smi_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // monitor: pops one expected read value per read cycle
  always @(negedge clk) begin
    #(PERIOD/4);
    if (rd_en) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL read with no expectation: actual %h expected none", rd_data);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (rd_data !== it.val) begin
          n_bad++;
          $display("FAIL %s addr %h: actual %h expected %h", it.tag, rd_addr, rd_data, it.val);
        end
      end
    end
  end

  task automatic step(input logic [1:0] t, input logic [2:0] u, input logic [5:0] c,
                      input bit rd, input logic [7:0] a, input string tag);
    logic [5:0] s;
    item_t it;
    @(negedge clk);
    evt_tmr = t; evt_udev = u; cfg_trap = c; rd_en = rd; rd_addr = a;
    s[0] = t[0] & tmr_ctl[0];
    s[1] = t[1] & tmr_ctl[1];
    s[2] = u[0] & udev_ctl[4];
    s[3] = u[1] & udev_ctl[5];
    s[4] = u[2] & udev_ctl[6];
    s[5] = |(c & cfg_trap_en);
    if (rd) begin
      if (a == 8'h00) it.val = {6'b0, |m_stat, 9'b0};
      else if (a == 8'h04 || a == 8'h06) it.val = {10'b0, m_stat};
      else it.val = 16'h0;
      it.tag = tag;
      exp_q.push_back(it);
      if (a == 8'h06) begin m_stat = '0; m_spd = 1'b0; end
      if (a == 8'h08 && spd_en) m_spd = 1'b1;
    end
    m_stat = m_stat | s;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(2'b0, 3'b0, 6'b0, 1'b1, a, tag);
  endtask

  task automatic chk_smi(input string tag);
    logic e;
    @(negedge clk);
    evt_tmr = '0; evt_udev = '0; cfg_trap = '0; rd_en = 1'b0; rd_addr = '0;
    #(PERIOD/4);
    e = (|m_stat) | m_spd;
    n_cmp++;
    if (smi_o !== e) begin
      n_bad++;
      $display("FAIL %s smi_o: actual %b expected %b", tag, smi_o, e);
    end
  endtask

  initial begin
    #(PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    evt_tmr = '0; evt_udev = '0; cfg_trap = '0; rd_en = 0; rd_addr = '0;
    tmr_ctl = 8'h03; udev_ctl = 8'h70; cfg_trap_en = 6'h3F; spd_en = 0;
    m_stat = '0; m_spd = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_smi("R1");
    rd(8'h06, "R1");
    rd(8'h04, "R1");
    rd(8'h00, "R1");

    // R2 / R8 / R6 / R7 timer 1 path
    step(2'b01, 3'b0, 6'b0, 0, 8'h00, "R2");
    chk_smi("R2");
    rd(8'h04, "R8");
    rd(8'h04, "R8");
    chk_smi("R8");
    rd(8'h00, "R6");
    rd(8'h06, "R7");
    chk_smi("R7");
    rd(8'h04, "R7");
    rd(8'h00, "R7");

    // R2 each source on its own bit
    step(2'b10, 3'b0, 6'b0, 0, 8'h00, "R2");
    rd(8'h06, "R2");
    for (int k = 0; k < 3; k++) begin
      step(2'b0, 3'(1 << k), 6'b0, 0, 8'h00, "R2");
      rd(8'h06, "R2");
    end
    for (int k = 0; k < 6; k++) begin
      step(2'b0, 3'b0, 6'(1 << k), 0, 8'h00, "R4");
      rd(8'h06, "R4");
    end
    chk_smi("R7");

    // R3 enables
    tmr_ctl = 8'h01;
    step(2'b10, 3'b0, 6'b0, 0, 8'h00, "R3");
    chk_smi("R3");
    rd(8'h04, "R3");
    udev_ctl = 8'h20;
    step(2'b0, 3'b111, 6'b0, 0, 8'h00, "R3");
    rd(8'h06, "R3");
    // R4 per-space enables
    cfg_trap_en = 6'b000100;
    step(2'b0, 3'b0, 6'b111011, 0, 8'h00, "R4");
    chk_smi("R4");
    rd(8'h04, "R4");
    step(2'b0, 3'b0, 6'b000100, 0, 8'h00, "R4");
    rd(8'h06, "R4");
    tmr_ctl = 8'h03; udev_ctl = 8'h70; cfg_trap_en = 6'h3F;

    // R5 sticky
    step(2'b01, 3'b0, 6'b0, 0, 8'h00, "R5");
    for (int k = 0; k < 5; k++) step(2'b0, 3'b0, 6'b0, 0, 8'h00, "R5");
    rd(8'h04, "R5");
    step(2'b0, 3'b100, 6'b0, 0, 8'h00, "R5");
    rd(8'h04, "R5");
    rd(8'h00, "R6");
    rd(8'h06, "R5");

    // R10 coincident event and clear
    step(2'b01, 3'b0, 6'b0, 0, 8'h00, "R10");
    step(2'b10, 3'b0, 6'b0, 1, 8'h06, "R10");
    chk_smi("R10");
    rd(8'h04, "R10");
    rd(8'h06, "R10");

    // R9 / R11 speedup
    rd(8'h08, "R9");
    chk_smi("R9");
    spd_en = 1;
    rd(8'h08, "R9");
    chk_smi("R11");
    rd(8'h04, "R11");
    rd(8'h00, "R11");
    rd(8'h06, "R9");
    chk_smi("R9");
    spd_en = 0;

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule